// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with High/Low Result Pair

This block performs 32-bit integer multiplication and division one bit per clock and keeps its results in two private registers: a high word and a low word. A processor pipeline hands it commands through a valid/ready handshake. Multiply and divide come in signed and unsigned forms. A product is split across the pair. A division leaves the quotient in the low word and the remainder in the high word. Separate commands write either register directly from an operand, or read either one back through a response port.

An arithmetic command holds the unit busy for a fixed number of cycles, whatever the operands are. While it is busy, the unit refuses all further commands, so a read issued just after an arithmetic command stalls and then returns the fresh result. No command ever signals an error. Division by zero gives a fixed, defined result. Signed overflow wraps silently.

Top module: `mdu_unit`

## Requirements
- R1: An unsigned multiply (cmd_op 3'b001) writes bits 31:0 of the 64-bit product of cmd_a and cmd_b to the low word and bits 63:32 to the high word.
- R2: A signed multiply (cmd_op 3'b000) treats both operands as two's complement and stores the 64-bit two's-complement product the same way as R1.
- R3: An unsigned divide (cmd_op 3'b011) stores cmd_a / cmd_b in the low word and cmd_a % cmd_b in the high word.
- R4: A signed divide (cmd_op 3'b010) rounds the quotient toward zero, and the remainder carries the sign of the dividend. Dividing 0x80000000 by -1 gives low 0x80000000 and high 0.
- R5: Dividing by zero, signed or unsigned, takes the normal cycle count. It leaves the low word all ones and the high word equal to the dividend, and it signals no error.
- R6: After an arithmetic command is accepted, busy stays high and cmd_ready stays low for exactly 32 cycles. The result can be read after that.
- R7: Set-high (cmd_op 3'b100) and set-low (cmd_op 3'b101) copy cmd_a into the named register at the acceptance edge.
- R8: Get-high (cmd_op 3'b110) and get-low (cmd_op 3'b111) raise rsp_valid for one cycle, one cycle after acceptance, with that register on rsp_data. A get issued while the unit is busy waits until the result is written.
- R9: A set command issued while an operation is running waits for it to finish and then replaces that operation's result in the named register. The other register keeps its result.
- R10: A synchronous active-high reset clears both registers and the busy state, so cmd_ready is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_op | input | 3 | Command code (see R1 to R8) |
| cmd_a | input | 32 | First operand / dividend / value for set commands |
| cmd_b | input | 32 | Second operand / divisor |
| busy | output | 1 | Arithmetic operation in progress |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 32 | Register value for a get command |

## Verification
The assertions assume that commands enter only through the handshake, so an operation never starts while another is running and a set never lands on the same edge as a result write. The bench follows this by driving cmd_valid on falling edges and holding each command until cmd_ready has been high across a rising edge. The assertions also assume that reset is held from time zero, and the bench does so for several cycles before it sends anything. Stalls come only from the unit itself, because the bench queues reads and sets straight after arithmetic commands.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  // bit 2 = register access, bit 1 = divide / get, bit 0 = unsigned / low
  typedef enum logic [2:0] {
    OP_MUL_S  = 3'b000,
    OP_MUL_U  = 3'b001,
    OP_DIV_S  = 3'b010,
    OP_DIV_U  = 3'b011,
    OP_SET_HI = 3'b100,
    OP_SET_LO = 3'b101,
    OP_GET_HI = 3'b110,
    OP_GET_LO = 3'b111
  } mdu_op_e;

endpackage

// File: rtl/mdu_seq.sv
module mdu_seq #(
  parameter int ITER = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;

  logic [CW-1:0] cnt;

  assign last = busy && (cnt == CW'(ITER - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  // R6: the top must never launch an operation over a running one
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         start,
  input  logic         op_div,
  input  logic         op_uns,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         step,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo
);
  localparam int PW = 2 * W;

  logic [PW-1:0] acc;      // {partial high / remainder, multiplier / quotient}
  logic [W-1:0]  opnd;     // multiplicand magnitude or divisor magnitude
  logic [W-1:0]  dvd;      // original dividend, kept for the zero-divisor case
  logic          is_div, neg_q, neg_r, dz;
  logic          cap_sgn;
  logic [PW-1:0] nxt;

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic sgn);
    return (sgn && v[W-1]) ? -v : v;
  endfunction

  // shift-add: conditionally add multiplicand into the top half, shift right
  function automatic logic [PW-1:0] mul_step(input logic [PW-1:0] p, input logic [W-1:0] m);
    logic [W:0] s;
    s = {1'b0, p[PW-1:W]} + (p[0] ? {1'b0, m} : {(W+1){1'b0}});
    return {s, p[W-1:1]};
  endfunction

  // restoring: shift left one bit, subtract divisor when it fits
  function automatic logic [PW-1:0] div_step(input logic [PW-1:0] p, input logic [W-1:0] d);
    logic [W:0] t;
    logic [W:0] diff;
    t    = {p[PW-1:W], p[W-1]};
    diff = t - {1'b0, d};
    if (t >= {1'b0, d}) return {diff[W-1:0], p[W-2:0], 1'b1};
    else                return {t[W-1:0],    p[W-2:0], 1'b0};
  endfunction

  assign cap_sgn = ~op_uns;
  assign nxt     = is_div ? div_step(acc, opnd) : mul_step(acc, opnd);

  always_ff @(posedge clk) begin
    if (start) begin
      acc    <= {{W{1'b0}}, magnitude(a, cap_sgn)};
      opnd   <= magnitude(b, cap_sgn);
      dvd    <= a;
      is_div <= op_div;
      neg_q  <= cap_sgn & (a[W-1] ^ b[W-1]);
      neg_r  <= cap_sgn & a[W-1];
      dz     <= op_div & (b == '0);
    end else if (step) begin
      acc <= nxt;
    end
  end

  // sign correction applied to the final step's output
  always_comb begin
    if (!is_div) begin
      {res_hi, res_lo} = neg_q ? -nxt : nxt;
    end else if (dz) begin
      res_lo = '1;
      res_hi = dvd;
    end else begin
      res_lo = neg_q ? -nxt[W-1:0]  : nxt[W-1:0];
      res_hi = neg_r ? -nxt[PW-1:W] : nxt[PW-1:W];
    end
  end

endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_res,
  input  logic [W-1:0] res_hi,
  input  logic [W-1:0] res_lo,
  input  logic         set_hi,
  input  logic         set_lo,
  input  logic [W-1:0] set_val,
  input  logic         get_hi,
  input  logic         get_lo,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_data
);
  logic [W-1:0] hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (set_hi)      hi_q <= set_val;
      else if (wr_res) hi_q <= res_hi;
      if (set_lo)      lo_q <= set_val;
      else if (wr_res) lo_q <= res_lo;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= get_hi | get_lo;
      if (get_hi)      rsp_data <= hi_q;
      else if (get_lo) rsp_data <= lo_q;
    end
  end

  // R8: a response only ever follows an accepted get
  a_r8_rsp_follows_get: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(get_hi | get_lo));

  // R7: a set-low lands in the low word on the next edge
  a_r7_set_lo_lands: assert property (@(posedge clk) disable iff (rst)
    set_lo |=> (lo_q == $past(set_val)));

  // R7: a set-high lands in the high word on the next edge
  a_r7_set_hi_lands: assert property (@(posedge clk) disable iff (rst)
    set_hi |=> (hi_q == $past(set_val)));

  // R9: a set is held off, so it never collides with a result write
  a_r9_no_set_on_result: assert property (@(posedge clk) disable iff (rst)
    wr_res |-> !(set_hi || set_lo));

endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_a,
  input  logic [W-1:0] cmd_b,
  output logic         busy,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_data
);
  localparam int KW = $clog2(W + 2);

  mdu_op_e      op;
  logic         accept, start, last;
  logic         set_hi, set_lo, get_hi, get_lo;
  logic [W-1:0] res_hi, res_lo;

  assign op        = mdu_op_e'(cmd_op);
  assign cmd_ready = ~busy;
  assign accept    = cmd_valid & cmd_ready;
  assign start     = accept & ~cmd_op[2];
  assign set_hi    = accept & (op == OP_SET_HI);
  assign set_lo    = accept & (op == OP_SET_LO);
  assign get_hi    = accept & (op == OP_GET_HI);
  assign get_lo    = accept & (op == OP_GET_LO);

  mdu_seq #(.ITER(W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .last  (last)
  );

  mdu_datapath #(.W(W)) u_dp (
    .clk    (clk),
    .start  (start),
    .op_div (cmd_op[1]),
    .op_uns (cmd_op[0]),
    .a      (cmd_a),
    .b      (cmd_b),
    .step   (busy),
    .res_hi (res_hi),
    .res_lo (res_lo)
  );

  mdu_hilo #(.W(W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_res    (last),
    .res_hi    (res_hi),
    .res_lo    (res_lo),
    .set_hi    (set_hi),
    .set_lo    (set_lo),
    .set_val   (cmd_a),
    .get_hi    (get_hi),
    .get_lo    (get_lo),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // independent cycle count for the busy window check
  logic [KW-1:0] chk_cnt;
  always_ff @(posedge clk) begin
    if (rst)        chk_cnt <= '0;
    else if (start) chk_cnt <= '0;
    else if (busy)  chk_cnt <= chk_cnt + 1'b1;
  end

  // R6: busy drops exactly W cycles after the operation was accepted
  a_r6_busy_window: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (chk_cnt == KW'(W)));

  // R8: no get is accepted while an operation is running
  a_r8_get_stalled: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(get_hi || get_lo));

endmodule

// File: tb/mdu_unit_tb.sv
`timescale 1ns/1ps
module mdu_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_a = '0;
  logic [31:0] cmd_b = '0;
  logic        busy;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mdu_unit u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // drive on a falling edge, hold until accepted at a rising edge
  task automatic send(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic get(input string req, input logic [2:0] op, output logic [31:0] d);
    send(op, 32'h0, 32'h0);
    check(req, "rsp_valid after get", {63'h0, rsp_valid}, 64'h1);
    d = rsp_data;
  endtask

  function automatic logic [63:0] model(input logic [2:0] op, input logic [31:0] a,
                                        input logic [31:0] b);
    logic signed [63:0] sa, sb, q, r;
    logic [63:0] ua, ub;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    ua = {32'h0, a};
    ub = {32'h0, b};
    case (op)
      3'b000: return sa * sb;
      3'b001: return ua * ub;
      3'b010: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        q = sa / sb; r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {ua[31:0] % ub[31:0], ua[31:0] / ub[31:0]};
      end
    endcase
  endfunction

  // one arithmetic scenario: latency plus both result words
  task automatic run_arith(input string req, input logic [2:0] op,
                           input logic [31:0] a, input logic [31:0] b);
    logic [63:0] exp;
    logic [31:0] hi, lo;
    int n;
    exp = model(op, a, b);
    send(op, a, b);
    check("R6", "cmd_ready low while busy", {63'h0, cmd_ready}, 64'h0);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    check("R6", "busy cycle count", 64'(n), 64'd32);
    get(req, 3'b110, hi);
    get(req, 3'b111, lo);
    check(req, "high word", {32'h0, hi}, {32'h0, exp[63:32]});
    check(req, "low word",  {32'h0, lo}, {32'h0, exp[31:0]});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R10", "cmd_ready after reset", {63'h0, cmd_ready}, 64'h1);
    check("R10", "busy after reset", {63'h0, busy}, 64'h0);
    get("R10", 3'b110, d); check("R10", "high word after reset", {32'h0, d}, 64'h0);
    get("R10", 3'b111, d); check("R10", "low word after reset", {32'h0, d}, 64'h0);
  endtask

  task automatic t_set_get;
    logic [31:0] d;
    send(3'b100, 32'hCAFE_0001, 32'h0);
    send(3'b101, 32'h0BAD_F00D, 32'h0);
    get("R8", 3'b110, d); check("R7", "set-high value", {32'h0, d}, 64'hCAFE_0001);
    get("R8", 3'b111, d); check("R7", "set-low value", {32'h0, d}, 64'h0BAD_F00D);
  endtask

  // get issued straight after a multiply must stall and see the new result
  task automatic t_stalled_get;
    logic [31:0] d;
    logic [63:0] exp;
    exp = model(3'b001, 32'h0001_0000, 32'h0003_0000);
    send(3'b001, 32'h0001_0000, 32'h0003_0000);
    get("R8", 3'b110, d);
    check("R8", "stalled get-high returns fresh result", {32'h0, d}, {32'h0, exp[63:32]});
  endtask

  // set-low queued behind a divide overwrites only the low word
  task automatic t_set_over_result;
    logic [31:0] d;
    logic [63:0] exp;
    exp = model(3'b011, 32'd1000, 32'd7);
    send(3'b011, 32'd1000, 32'd7);
    send(3'b101, 32'h5555_AAAA, 32'h0);
    get("R9", 3'b111, d); check("R9", "low word replaced by set", {32'h0, d}, 64'h5555_AAAA);
    get("R9", 3'b110, d); check("R9", "high word keeps remainder", {32'h0, d}, {32'h0, exp[63:32]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_set_get();
    run_arith("R1", 3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_arith("R1", 3'b001, 32'h1234_5678, 32'h9ABC_DEF0);
    run_arith("R2", 3'b000, 32'hFFFF_FFFD, 32'd5);
    run_arith("R2", 3'b000, 32'h8000_0000, 32'h8000_0000);
    run_arith("R2", 3'b000, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    run_arith("R3", 3'b011, 32'd100, 32'd7);
    run_arith("R3", 3'b011, 32'hFFFF_FFFF, 32'd3);
    run_arith("R4", 3'b010, 32'hFFFF_FFF9, 32'd2);
    run_arith("R4", 3'b010, 32'd7, 32'hFFFF_FFFE);
    run_arith("R4", 3'b010, 32'h8000_0000, 32'hFFFF_FFFF);
    run_arith("R5", 3'b011, 32'h1234_5678, 32'h0);
    run_arith("R5", 3'b010, 32'hFFFF_FF00, 32'h0);
    t_stalled_get();
    t_set_over_result();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule